// File: doc/BRIEF.md
# Serial-to-Parallel Output Shifter

This block feeds a chain of external serial-in, parallel-out shift registers. These usually drive LEDs or slow control lines. Software keeps an output image of up to three 8-bit groups in the block through a small register write port. Each time the value to be shown changes, the block sends a serial frame on three pins: data, shift clock and store strobe. The frame holds only the groups that are enabled, and the store strobe then latches the frame into the chain.

Some bits of the lowest group can be handed to hardware. A modem status input can own the two lowest bits. Two PHY status inputs can own three bits each. A bit that is handed over takes its value from the status input and not from the software image. A change on an owned input starts a new frame in the same way as a software write. A change that arrives while a frame is on the pins is held and sent in the next frame.

Top module: `stp_shifter`

## Requirements
- R1: After reset, the image holds the SHADOW parameter and the configuration holds CFG_RESET (default: all three groups enabled, data launched on the falling edge, no hardware owners). No frame is sent until the value to show changes. The pins and busy are low.
- R2: Hardware ownership of group 0 works as follows. Config bits [5:4] give modem_st[1:0] ownership of image bits [1:0]. Config bits [8:6] give phy1_st[2:0] ownership of bits [4:2]. Config bits [11:9] give phy2_st[2:0] ownership of bits [7:5]. An owned bit takes the input value, and a bit that is not owned takes the software image bit. An input whose enable is clear has no effect on the pins.
- R3: A write with wr_addr=0 sets the image, and a write with wr_addr=1 sets the configuration. Config bits [2:0] enable groups 2..0, where group g is image bits [8g+7:8g]. Only enabled groups are sent. They go highest group first, and each group goes MSB first.
- R4: Config bit [3] clear means data changes when shift_clk falls and is sampled on the rise. When the bit is set, data changes when the clock rises and is sampled on the fall.
- R5: After the last bit, store_stb pulses high for exactly one system cycle. During the pulse shift_clk and shift_data are low.
- R6: A change that arrives during a frame is held. One further frame then carries the latest value.
- R7: With all groups disabled, no frame is sent and store_stb never pulses.
- R8: busy is high from frame launch until the store pulse ends.
- R9: While busy is low, shift_clk, shift_data and store_stb are low.
- R10: A change to the image, or to any owned status input, starts a frame.
- R11: Each bit lasts DIV system cycles, half at each clock level.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 1 | 0 = image, 1 = configuration |
| wr_data | input | 24 | Write data |
| modem_st | input | 2 | Modem status bits |
| phy1_st | input | 3 | First PHY status bits |
| phy2_st | input | 3 | Second PHY status bits |
| shift_clk | output | 1 | Shift clock to the chain |
| shift_data | output | 1 | Serial data to the chain |
| store_stb | output | 1 | Latch strobe to the chain |
| busy | output | 1 | Frame in progress |

## Verification
Two events can fall in the same stretch of cycles: an image change arriving while a frame is still being shifted, and the store pulse that ends that frame. The bench writes a second image a few cycles after the first frame launches. It then checks that exactly two frames appear, that the last latched frame carries the second value, and that busy was high in mid-frame. A bench model of the ownership merge and group packing judges every captured frame. It samples the data on the configured clock edge and checks the bit period and the idle levels.

// File: rtl/stp_pkg.sv
package stp_pkg;
  localparam int CFG_W      = 12;
  localparam int MODEM_LSB  = 0;
  localparam int PHY1_LSB   = 2;
  localparam int PHY2_LSB   = 5;

  typedef struct packed {
    logic [2:0] phy2_en;
    logic [2:0] phy1_en;
    logic [1:0] modem_en;
    logic       rise_mode;
    logic [2:0] grp_en;
  } stp_cfg_t;

  typedef enum logic [1:0] {S_IDLE, S_SHIFT, S_STORE} ser_state_t;
endpackage

// File: rtl/stp_regs.sv
module stp_regs
  import stp_pkg::*;
#(
  parameter int                   IMG_W     = 24,
  parameter logic [IMG_W-1:0]     SHADOW    = '0,
  parameter logic [CFG_W-1:0]     CFG_RESET = 12'h007
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             wr_en,
  input  logic             wr_addr,
  input  logic [IMG_W-1:0] wr_data,
  input  logic [1:0]       modem_st,
  input  logic [2:0]       phy1_st,
  input  logic [2:0]       phy2_st,
  output stp_cfg_t         cfg,
  output logic [IMG_W-1:0] eff_img
);
  logic [IMG_W-1:0] img_q;
  logic [IMG_W-1:0] merged;

  always_ff @(posedge clk) begin
    if (rst) begin
      img_q <= SHADOW;
      cfg   <= stp_cfg_t'(CFG_RESET);
    end else if (wr_en) begin
      if (!wr_addr) img_q <= wr_data;
      else          cfg   <= stp_cfg_t'(wr_data[CFG_W-1:0]);
    end
  end

  // Per-bit ownership merge
  always_comb begin
    merged = img_q;
    for (int i = 0; i < 2; i++)
      if (cfg.modem_en[i]) merged[MODEM_LSB+i] = modem_st[i];
    for (int i = 0; i < 3; i++) begin
      if (cfg.phy1_en[i]) merged[PHY1_LSB+i] = phy1_st[i];
      if (cfg.phy2_en[i]) merged[PHY2_LSB+i] = phy2_st[i];
    end
  end

  always_ff @(posedge clk) eff_img <= merged;

  a_r2_modem_owner: assert property (@(posedge clk) disable iff (rst)
    $past(cfg.modem_en[0]) |-> eff_img[0] == $past(modem_st[0]));
  a_r2_software_bit: assert property (@(posedge clk) disable iff (rst)
    !$past(cfg.phy2_en[2]) |-> eff_img[7] == $past(img_q[7]));
endmodule

// File: rtl/stp_frame_ctrl.sv
module stp_frame_ctrl #(
  parameter int NGRP  = 3,
  parameter int GW    = 8,
  parameter int LEN_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic [NGRP*GW-1:0]   eff_img,
  input  logic [NGRP-1:0]      grp_en,
  input  logic                 ser_busy,
  output logic                 start,
  output logic [NGRP*GW-1:0]   frame_vec,
  output logic [LEN_W-1:0]     frame_len
);
  localparam int IMG_W = NGRP * GW;

  logic [IMG_W-1:0] eff_last;
  logic [IMG_W-1:0] pack_vec;
  logic [LEN_W-1:0] pack_len;
  logic             dirty;
  logic             launch;
  logic             changed;

  // Left-align enabled groups, highest group first
  always_comb begin
    int pos;
    pos      = IMG_W;
    pack_vec = '0;
    pack_len = '0;
    for (int g = NGRP - 1; g >= 0; g--) begin
      if (grp_en[g]) begin
        pos = pos - GW;
        pack_vec[pos +: GW] = eff_img[g*GW +: GW];
        pack_len = pack_len + LEN_W'(GW);
      end
    end
  end

  assign changed = (eff_img != eff_last);
  assign launch  = dirty && !ser_busy && !start && (grp_en != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      eff_last  <= eff_img;
      dirty     <= 1'b0;
      start     <= 1'b0;
      frame_vec <= '0;
      frame_len <= '0;
    end else begin
      eff_last <= eff_img;
      start    <= launch;
      if (launch) begin
        frame_vec <= pack_vec;
        frame_len <= pack_len;
      end
      if (grp_en == '0)  dirty <= 1'b0;
      else if (changed)  dirty <= 1'b1;
      else if (launch)   dirty <= 1'b0;
    end
  end

  a_r6_single_start: assert property (@(posedge clk) disable iff (rst)
    start |=> !start);
  a_r7_no_start_disabled: assert property (@(posedge clk) disable iff (rst)
    (grp_en == '0) |=> !start);
  a_r6_pending_kept: assert property (@(posedge clk) disable iff (rst)
    (dirty && ser_busy && !changed && (grp_en != '0)) |=> dirty);
endmodule

// File: rtl/stp_serializer.sv
module stp_serializer
  import stp_pkg::*;
#(
  parameter int IMG_W = 24,
  parameter int LEN_W = 5,
  parameter int DIV   = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start,
  input  logic [IMG_W-1:0] vec,
  input  logic [LEN_W-1:0] len,
  input  logic             rise_mode,
  output logic             shift_clk,
  output logic             shift_data,
  output logic             store_stb,
  output logic             busy
);
  localparam int HALF  = DIV / 2;
  localparam int CNT_W = (DIV > 2) ? $clog2(DIV) : 1;

  ser_state_t       state;
  logic [IMG_W-1:0] sreg;
  logic [LEN_W-1:0] left;
  logic [CNT_W-1:0] cnt;
  logic             mode_q;

  assign busy = (state != S_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= S_IDLE;
      sreg       <= '0;
      left       <= '0;
      cnt        <= '0;
      mode_q     <= 1'b0;
      shift_clk  <= 1'b0;
      shift_data <= 1'b0;
      store_stb  <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          if (start) begin
            state      <= S_SHIFT;
            mode_q     <= rise_mode;
            shift_clk  <= rise_mode;
            shift_data <= vec[IMG_W-1];
            sreg       <= vec << 1;
            left       <= len - LEN_W'(1);
            cnt        <= '0;
          end
        end
        S_SHIFT: begin
          cnt <= cnt + CNT_W'(1);
          if (cnt == CNT_W'(HALF - 1)) shift_clk <= ~shift_clk;
          if (cnt == CNT_W'(DIV - 1)) begin
            cnt <= '0;
            if (left == '0) begin
              state      <= S_STORE;
              shift_clk  <= 1'b0;
              shift_data <= 1'b0;
              store_stb  <= 1'b1;
            end else begin
              shift_clk  <= mode_q;
              shift_data <= sreg[IMG_W-1];
              sreg       <= sreg << 1;
              left       <= left - LEN_W'(1);
            end
          end
        end
        default: begin
          store_stb <= 1'b0;
          state     <= S_IDLE;
        end
      endcase
    end
  end

  a_r5_store_single: assert property (@(posedge clk) disable iff (rst)
    store_stb |=> !store_stb);
  a_r5_store_quiet: assert property (@(posedge clk) disable iff (rst)
    store_stb |-> (!shift_clk && !shift_data));
  a_r9_idle_low: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!shift_clk && !shift_data && !store_stb));
  a_r8_busy_at_store: assert property (@(posedge clk) disable iff (rst)
    store_stb |-> busy);
endmodule

// File: rtl/stp_shifter.sv
module stp_shifter
  import stp_pkg::*;
#(
  parameter int                       NGRP      = 3,
  parameter int                       GW        = 8,
  parameter int                       DIV       = 4,
  parameter logic [NGRP*GW-1:0]       SHADOW    = 24'h0000FF,
  parameter logic [CFG_W-1:0]         CFG_RESET = 12'h007
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 wr_en,
  input  logic                 wr_addr,
  input  logic [NGRP*GW-1:0]   wr_data,
  input  logic [1:0]           modem_st,
  input  logic [2:0]           phy1_st,
  input  logic [2:0]           phy2_st,
  output logic                 shift_clk,
  output logic                 shift_data,
  output logic                 store_stb,
  output logic                 busy
);
  localparam int IMG_W = NGRP * GW;
  localparam int LEN_W = $clog2(IMG_W + 1);

  stp_cfg_t         cfg;
  logic [IMG_W-1:0] eff_img;
  logic [IMG_W-1:0] frame_vec;
  logic [LEN_W-1:0] frame_len;
  logic             start;
  logic             ser_busy;

  stp_regs #(.IMG_W(IMG_W), .SHADOW(SHADOW), .CFG_RESET(CFG_RESET)) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .modem_st(modem_st), .phy1_st(phy1_st), .phy2_st(phy2_st),
    .cfg(cfg), .eff_img(eff_img));

  stp_frame_ctrl #(.NGRP(NGRP), .GW(GW), .LEN_W(LEN_W)) u_ctrl (
    .clk(clk), .rst(rst), .eff_img(eff_img), .grp_en(cfg.grp_en[NGRP-1:0]),
    .ser_busy(ser_busy), .start(start), .frame_vec(frame_vec),
    .frame_len(frame_len));

  stp_serializer #(.IMG_W(IMG_W), .LEN_W(LEN_W), .DIV(DIV)) u_ser (
    .clk(clk), .rst(rst), .start(start), .vec(frame_vec), .len(frame_len),
    .rise_mode(cfg.rise_mode), .shift_clk(shift_clk), .shift_data(shift_data),
    .store_stb(store_stb), .busy(ser_busy));

  assign busy = ser_busy | start;

  a_r8_launch_busy: assert property (@(posedge clk) disable iff (rst)
    start |=> busy);
endmodule

// File: tb/sim_stp_shifter.sv
module sim_stp_shifter;
  localparam int DIV = 4;
  localparam logic [23:0] SHADOW = 24'h0000FF;

  logic clk = 0, rst = 1, wr_en = 0, wr_addr = 0;
  logic [23:0] wr_data = '0;
  logic [1:0] modem_st = '0;
  logic [2:0] phy1_st = '0, phy2_st = '0;
  logic shift_clk, shift_data, store_stb, busy;

  int checks = 0, fails = 0;
  bit mon_rise = 0;
  logic [23:0] cap_bits = '0, last_vec = '0;
  int samp_cnt = 0, last_len = 0, frame_cnt = 0, since_edge = 0;
  int idle_err = 0, store_err = 0, period_err = 0;
  logic prev_clk = 0, prev_store = 0;
  logic [23:0] cur_img = SHADOW;
  logic [11:0] cur_cfg = 12'h007;

  always #5 clk = ~clk;

  stp_shifter u0 (.clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .modem_st(modem_st), .phy1_st(phy1_st), .phy2_st(phy2_st),
    .shift_clk(shift_clk), .shift_data(shift_data), .store_stb(store_stb),
    .busy(busy));

  // Pin monitor, sampled between active edges
  always @(negedge clk) begin
    if (!rst) begin
      since_edge++;
      if (!busy && (shift_clk || shift_data || store_stb)) idle_err++;
      if ((!mon_rise && shift_clk && !prev_clk) || (mon_rise && !shift_clk && prev_clk)) begin
        if (samp_cnt > 0 && since_edge != DIV) period_err++;
        since_edge = 0;
        cap_bits = {cap_bits[22:0], shift_data};
        samp_cnt++;
      end
      if (store_stb) begin
        if (prev_store || shift_clk || shift_data) store_err++;
        if (!prev_store) begin
          last_len  = samp_cnt;
          last_vec  = (samp_cnt > 0) ? cap_bits << (24 - samp_cnt) : '0;
          frame_cnt++;
          samp_cnt  = 0;
          cap_bits  = '0;
        end
      end
    end
    prev_clk   = shift_clk;
    prev_store = store_stb;
  end

  function automatic logic [11:0] mk_cfg(input logic [2:0] g, input logic r,
      input logic [1:0] m, input logic [2:0] p1, input logic [2:0] p2);
    return {p2, p1, m, r, g};
  endfunction

  function automatic void expect_frame(input logic [23:0] img, input logic [11:0] c,
      input logic [1:0] m, input logic [2:0] p1, input logic [2:0] p2,
      output logic [23:0] vec, output int len);
    logic [23:0] e;
    e = img;
    for (int i = 0; i < 2; i++) if (c[4+i]) e[i] = m[i];
    for (int i = 0; i < 3; i++) begin
      if (c[6+i]) e[2+i] = p1[i];
      if (c[9+i]) e[5+i] = p2[i];
    end
    vec = '0; len = 0;
    for (int g = 2; g >= 0; g--)
      if (c[g]) begin
        vec[23-len -: 8] = e[g*8 +: 8];
        len += 8;
      end
  endfunction

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic a, input logic [23:0] d);
    @(negedge clk);
    wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 0;
    if (a) cur_cfg = d[11:0]; else cur_img = d;
  endtask

  task automatic wait_idle();
    int quiet = 0;
    for (int n = 0; n < 4000 && quiet < 12; n++) begin
      @(negedge clk);
      if (busy) quiet = 0; else quiet++;
    end
  endtask

  task automatic check_last(input string tag);
    logic [23:0] ev; int el;
    expect_frame(cur_img, cur_cfg, modem_st, phy1_st, phy2_st, ev, el);
    check(last_vec == ev, tag, last_vec, ev);
    check(last_len == el, tag, last_len, el);
  endtask

  task automatic do_reset();
    rst = 1;
    repeat (4) @(negedge clk);
    rst = 0;
    cur_img = SHADOW; cur_cfg = 12'h007; mon_rise = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    int f0, s0;
    logic [23:0] r;
    void'($urandom(32'd4711));
    do_reset();
    @(negedge clk);
    check(!busy && !shift_clk && !shift_data && !store_stb, "R1 reset outputs", {busy, shift_clk, shift_data, store_stb}, 0);
    repeat (40) @(negedge clk);
    check(frame_cnt == 0, "R1 no frame after reset", frame_cnt, 0);

    // R1: shadow is the image after reset, seen through one owned bit
    modem_st = 2'b00;
    wr(1, {12'h0, mk_cfg(3'b001, 0, 2'b01, 3'b0, 3'b0)});
    wait_idle();
    check(frame_cnt == 1, "R1 R10 owner enable frame", frame_cnt, 1);
    check(last_vec[23:16] == 8'hFE, "R1 shadow image", last_vec[23:16], 8'hFE);

    // R3: all groups, falling edge
    wr(1, {12'h0, mk_cfg(3'b111, 0, 2'b0, 3'b0, 3'b0)});
    wait_idle();
    wr(0, 24'hA53C96);
    wait_idle();
    check_last("R3 all groups order");

    // R3: groups 2 and 0
    wr(1, {12'h0, mk_cfg(3'b101, 0, 2'b0, 3'b0, 3'b0)});
    wait_idle();
    wr(0, 24'h1E77C3);
    wait_idle();
    check_last("R3 sparse groups");

    // R4: rising-edge launch
    mon_rise = 1;
    wr(1, {12'h0, mk_cfg(3'b111, 1, 2'b0, 3'b0, 3'b0)});
    wait_idle();
    wr(0, 24'h5AC3F0);
    wait_idle();
    check_last("R4 rising edge mode");
    mon_rise = 0;

    // R2: owner merge
    modem_st = 2'b10; phy1_st = 3'b011; phy2_st = 3'b110;
    wr(1, {12'h0, mk_cfg(3'b001, 0, 2'b11, 3'b101, 3'b010)});
    wait_idle();
    check_last("R2 owner merge");

    // R10: owned input change starts a frame
    f0 = frame_cnt;
    @(negedge clk); phy2_st = 3'b100;
    wait_idle();
    check(frame_cnt == f0 + 1, "R10 owned input change", frame_cnt, f0 + 1);
    check_last("R10 owned input value");

    // R2: unowned input ignored
    f0 = frame_cnt;
    @(negedge clk); phy1_st = 3'b001;
    wait_idle();
    check(frame_cnt == f0, "R2 unowned input ignored", frame_cnt, f0);

    // R6 / R8: change during frame
    wr(1, {12'h0, mk_cfg(3'b111, 0, 2'b0, 3'b0, 3'b0)});
    wait_idle();
    f0 = frame_cnt;
    wr(0, 24'h123456);
    repeat (8) @(negedge clk);
    check(busy, "R8 busy mid frame", busy, 1);
    wr(0, 24'hFEDCBA);
    wait_idle();
    check(frame_cnt == f0 + 2, "R6 pending frame count", frame_cnt, f0 + 2);
    check_last("R6 pending latest value");

    // R7: all groups disabled
    wr(1, {12'h0, mk_cfg(3'b000, 0, 2'b0, 3'b0, 3'b0)});
    wait_idle();
    s0 = frame_cnt;
    wr(0, 24'h0F0F0F);
    repeat (200) @(negedge clk);
    check(frame_cnt == s0 && !busy, "R7 disabled no strobe", frame_cnt, s0);

    // Random mix
    for (int it = 0; it < 24; it++) begin
      logic [2:0] g;
      g = 3'($urandom_range(1, 7));
      mon_rise = 1'($urandom);
      wr(1, {12'h0, mk_cfg(g, mon_rise, 2'($urandom), 3'($urandom), 3'($urandom))});
      wait_idle();
      @(negedge clk);
      modem_st = 2'($urandom); phy1_st = 3'($urandom); phy2_st = 3'($urandom);
      wait_idle();
      r = 24'($urandom) | 24'h800000;
      wr(0, cur_img ^ r);
      wait_idle();
      check_last("R2 R3 R4 random frame");
    end

    check(idle_err == 0, "R9 idle pins low", idle_err, 0);
    check(store_err == 0, "R5 store pulse", store_err, 0);
    check(period_err == 0, "R11 bit period", period_err, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule